// File: doc/BRIEF.md
# Display Window CRC Checker Channel

This block watches a raster pixel stream and computes a CRC-32 signature over the pixels that fall inside one rectangular region of the picture. It follows the stream with a row counter and a column counter, feeds each pixel inside the rectangle into a running checksum, and seals the checksum when the next frame begins. The sealed value is held on an output for the whole following frame. It is also compared with a reference signature supplied from outside, and a one-cycle pulse flags any difference. The block can detect a frozen, shifted or corrupted region of a display (a warning icon, for example) without checking the whole picture.

The rectangle limits, the reference signature and a channel enable come in as plain inputs; the block stores no configuration of its own. A polarity input selects which edge of the incoming pixel clock samples the stream. Change it only while reset is asserted.

Top module: `pix_win_crc`

## Requirements
- R1: While reset is asserted, `frame_crc_o` is 0 and `crc_fail_o` is 0.
- R2: The signature uses generator 0x04C11DB7. The register is preset to 0xFFFFFFFF on every frame edge, shifts MSB first, is not reflected and gets no final XOR. Each accepted pixel enters as three bytes, `pix_data_i[23:16]` first, then `[15:8]`, then `[7:0]`.
- R3: A pixel is accepted when `de_i` is high, the channel is enabled, and its position lies inside the rectangle with both limits inclusive. Its row is the number of active lines (falling edges of `de_i`) since the last rising `vsync_i`. Its column is the number of `de_i`-high pixels since the last rising `hsync_i`. Both count from 0.
- R4: `frame_crc_o` changes only on the sampling edge where `vsync_i` is first seen high, and only for an armed frame. It then takes the signature of the frame just ended and holds it until the next such edge. It is readable from the following cycle.
- R5: When a sealed signature differs from `ref_crc_i`, `crc_fail_o` is high for exactly the one cycle after that edge.
- R6: When the sealed signature equals `ref_crc_i`, `crc_fail_o` stays low.
- R7: If the start exceeds the end on either axis, no pixel is accepted, and the sealed signature is 0xFFFFFFFF.
- R8: With `chan_en_i` low, no pixel is accepted, `frame_crc_o` holds and `crc_fail_o` stays low. A frame is armed only if `chan_en_i` was high at the frame edge that began it, so the first frame edge after enable and the partial frame that follows it seal nothing.
- R9: With `clk_inv_i` = 0 the stream is sampled on the rising edge of `pix_clk_i`; with `clk_inv_i` = 1 it is sampled on the falling edge. The behaviour is otherwise identical.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pix_clk_i | input | 1 | Incoming pixel clock |
| clk_inv_i | input | 1 | 1 selects the falling edge of the pixel clock for sampling |
| rst_ni | input | 1 | Asynchronous active-low reset |
| chan_en_i | input | 1 | Channel enable |
| vsync_i | input | 1 | Frame sync, active high; its rising edge is the frame edge |
| hsync_i | input | 1 | Line sync, active high; its rising edge clears the column |
| de_i | input | 1 | Data enable, high for active pixels |
| pix_data_i | input | 24 | Pixel, red in the top byte |
| win_row_lo_i | input | 12 | First row of the rectangle |
| win_row_hi_i | input | 12 | Last row of the rectangle |
| win_col_lo_i | input | 13 | First column of the rectangle |
| win_col_hi_i | input | 13 | Last column of the rectangle |
| ref_crc_i | input | 32 | Expected signature |
| frame_crc_o | output | 32 | Sealed signature of the last armed frame |
| crc_fail_o | output | 1 | One-cycle mismatch pulse |

## Verification
The mismatch assertions assume that `ref_crc_i` does not change in the cycle after a frame edge. The stimulus therefore changes the reference only in mid-frame, after the two-cycle sync pulse has ended. The position logic assumes that `de_i` is low whenever `vsync_i` or `hsync_i` rises. The generated frames have blanking cycles around every sync pulse, and the polarity input is changed only while reset is held.

// File: rtl/pwc_pkg.sv
`timescale 1ns/1ps
package pwc_pkg;
    localparam int ROW_W  = 12;
    localparam int COL_W  = 13;
    localparam int PIX_W  = 24;
    localparam int CRC_W  = 32;
    localparam logic [CRC_W-1:0] CRC_POLY = 32'h04C11DB7;
    localparam logic [CRC_W-1:0] CRC_SEED = 32'hFFFFFFFF;

    // one byte, most significant bit first, no reflection
    function automatic logic [CRC_W-1:0] crc_byte(input logic [CRC_W-1:0] c,
                                                  input logic [7:0] b);
        logic [CRC_W-1:0] r;
        r = c;
        for (int i = 7; i >= 0; i--) begin
            if (r[CRC_W-1] ^ b[i]) r = (r << 1) ^ CRC_POLY;
            else                   r = r << 1;
        end
        return r;
    endfunction
endpackage

// File: rtl/pwc_clk_pol.sv
`timescale 1ns/1ps
module pwc_clk_pol (
    input  logic clk_i,
    input  logic inv_i,
    output logic clk_o
);
    assign clk_o = clk_i ^ inv_i;
endmodule

// File: rtl/pwc_raster.sv
`timescale 1ns/1ps
module pwc_raster #(
    parameter int ROW_W = pwc_pkg::ROW_W,
    parameter int COL_W = pwc_pkg::COL_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             vsync_i,
    input  logic             hsync_i,
    input  logic             de_i,
    input  logic [ROW_W-1:0] row_lo_i,
    input  logic [ROW_W-1:0] row_hi_i,
    input  logic [COL_W-1:0] col_lo_i,
    input  logic [COL_W-1:0] col_hi_i,
    output logic             frame_edge_o,
    output logic             hit_o
);
    localparam logic [ROW_W-1:0] ROW_MAX = '1;
    localparam logic [COL_W-1:0] COL_MAX = '1;

    typedef struct packed {
        logic             vs;
        logic             hs;
        logic             de;
        logic [ROW_W-1:0] row;
        logic [COL_W-1:0] col;
    } rast_t;

    rast_t s_d, s_q;
    logic  line_start, line_done, in_rows, in_cols;

    always_comb begin
        frame_edge_o = vsync_i & ~s_q.vs;
        line_start   = hsync_i & ~s_q.hs;
        line_done    = s_q.de & ~de_i;
        in_rows      = (s_q.row >= row_lo_i) && (s_q.row <= row_hi_i);
        in_cols      = (s_q.col >= col_lo_i) && (s_q.col <= col_hi_i);
        hit_o        = de_i && !frame_edge_o && in_rows && in_cols;

        s_d    = s_q;
        s_d.vs = vsync_i;
        s_d.hs = hsync_i;
        s_d.de = de_i;
        if (frame_edge_o) begin
            s_d.row = '0;
            s_d.col = '0;
        end else begin
            if (line_done && s_q.row != ROW_MAX) s_d.row = s_q.row + 1'b1;
            if (line_start)                        s_d.col = '0;
            else if (de_i && s_q.col != COL_MAX)   s_d.col = s_q.col + 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end
endmodule

// File: rtl/pwc_crc_engine.sv
`timescale 1ns/1ps
module pwc_crc_engine #(
    parameter int PIX_W = pwc_pkg::PIX_W
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     restart_i,
    input  logic                     feed_i,
    input  logic [PIX_W-1:0]         pix_i,
    output logic [pwc_pkg::CRC_W-1:0] crc_o
);
    localparam int NBYTES = PIX_W / 8;

    typedef struct packed {
        logic [pwc_pkg::CRC_W-1:0] crc;
    } crc_st_t;

    crc_st_t                   s_d, s_q;
    logic [pwc_pkg::CRC_W-1:0] acc;

    always_comb begin
        acc = s_q.crc;
        for (int b = 0; b < NBYTES; b++)
            acc = pwc_pkg::crc_byte(acc, pix_i[PIX_W-1-8*b -: 8]);

        s_d = s_q;
        if (restart_i)   s_d.crc = pwc_pkg::CRC_SEED;
        else if (feed_i) s_d.crc = acc;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '{crc: pwc_pkg::CRC_SEED};
        else        s_q <= s_d;
    end

    assign crc_o = s_q.crc;
endmodule

// File: rtl/pwc_frame_judge.sv
`timescale 1ns/1ps
module pwc_frame_judge #(
    parameter int CRC_W = pwc_pkg::CRC_W
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             frame_edge_i,
    input  logic [CRC_W-1:0] crc_i,
    input  logic [CRC_W-1:0] ref_i,
    output logic [CRC_W-1:0] last_o,
    output logic             fail_o
);
    typedef struct packed {
        logic             armed;
        logic [CRC_W-1:0] last;
        logic             fail;
    } judge_t;

    judge_t s_d, s_q;

    always_comb begin
        s_d      = s_q;
        s_d.fail = 1'b0;
        if (!en_i) begin
            s_d.armed = 1'b0;
        end else if (frame_edge_i) begin
            if (s_q.armed) begin
                s_d.last = crc_i;
                s_d.fail = (crc_i != ref_i);
            end
            s_d.armed = 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign last_o = s_q.last;
    assign fail_o = s_q.fail;
endmodule

// File: rtl/pix_win_crc.sv
`timescale 1ns/1ps
module pix_win_crc #(
    parameter int ROW_W = pwc_pkg::ROW_W,
    parameter int COL_W = pwc_pkg::COL_W,
    parameter int PIX_W = pwc_pkg::PIX_W
) (
    input  logic                      pix_clk_i,
    input  logic                      clk_inv_i,
    input  logic                      rst_ni,
    input  logic                      chan_en_i,
    input  logic                      vsync_i,
    input  logic                      hsync_i,
    input  logic                      de_i,
    input  logic [PIX_W-1:0]          pix_data_i,
    input  logic [ROW_W-1:0]          win_row_lo_i,
    input  logic [ROW_W-1:0]          win_row_hi_i,
    input  logic [COL_W-1:0]          win_col_lo_i,
    input  logic [COL_W-1:0]          win_col_hi_i,
    input  logic [pwc_pkg::CRC_W-1:0] ref_crc_i,
    output logic [pwc_pkg::CRC_W-1:0] frame_crc_o,
    output logic                      crc_fail_o
);
    localparam int CRC_W = pwc_pkg::CRC_W;

    logic             samp_clk;
    logic             frame_edge;
    logic             hit;
    logic [CRC_W-1:0] run_crc;

    pwc_clk_pol u_pol (
        .clk_i (pix_clk_i),
        .inv_i (clk_inv_i),
        .clk_o (samp_clk)
    );

    pwc_raster #(.ROW_W(ROW_W), .COL_W(COL_W)) u_rast (
        .clk          (samp_clk),
        .rst_n        (rst_ni),
        .vsync_i      (vsync_i),
        .hsync_i      (hsync_i),
        .de_i         (de_i),
        .row_lo_i     (win_row_lo_i),
        .row_hi_i     (win_row_hi_i),
        .col_lo_i     (win_col_lo_i),
        .col_hi_i     (win_col_hi_i),
        .frame_edge_o (frame_edge),
        .hit_o        (hit)
    );

    pwc_crc_engine #(.PIX_W(PIX_W)) u_crc (
        .clk       (samp_clk),
        .rst_n     (rst_ni),
        .restart_i (frame_edge),
        .feed_i    (hit & chan_en_i),
        .pix_i     (pix_data_i),
        .crc_o     (run_crc)
    );

    pwc_frame_judge #(.CRC_W(CRC_W)) u_judge (
        .clk          (samp_clk),
        .rst_n        (rst_ni),
        .en_i         (chan_en_i),
        .frame_edge_i (frame_edge),
        .crc_i        (run_crc),
        .ref_i        (ref_crc_i),
        .last_o       (frame_crc_o),
        .fail_o       (crc_fail_o)
    );
endmodule

// File: rtl/pwc_checker.sv
`timescale 1ns/1ps
module pwc_checker (
    input logic        clk,
    input logic        rst_n,
    input logic        en,
    input logic        vsync,
    input logic [31:0] ref_crc,
    input logic [31:0] frame_crc,
    input logic        fail
);
    // R5
    fail_single_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |=> !fail);

    // R5
    fail_after_sync_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> $past(vsync));

    // R8
    fail_needs_enable_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> $past(en));

    // R4
    crc_moves_on_edge_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_crc != $past(frame_crc)) |-> ($past(vsync) && $past(en)));

    // R5
    fail_means_diff_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fail |-> (frame_crc != ref_crc));

    // R6
    new_match_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((frame_crc != $past(frame_crc)) && !fail) |-> (frame_crc == ref_crc));
endmodule

bind pix_win_crc pwc_checker u_chk (
    .clk       (samp_clk),
    .rst_n     (rst_ni),
    .en        (chan_en_i),
    .vsync     (vsync_i),
    .ref_crc   (ref_crc_i),
    .frame_crc (frame_crc_o),
    .fail      (crc_fail_o)
);

// File: tb/pix_win_crc_test.sv
`timescale 1ns/1ps
module pix_win_crc_test;
    logic        pclk = 1'b0;
    logic        clk_inv = 1'b0;
    logic        rst_n = 1'b0;
    logic        chan_en = 1'b0;
    logic        vsync = 1'b0;
    logic        hsync = 1'b0;
    logic        de = 1'b0;
    logic [23:0] pix = '0;
    logic [11:0] rlo = '0, rhi = '0;
    logic [12:0] clo = '0, chi = '0;
    logic [31:0] ref_crc = '0;
    logic [31:0] frame_crc;
    logic        fail;

    always #10 pclk = ~pclk;   // 50 MHz

    pix_win_crc uut (
        .pix_clk_i(pclk), .clk_inv_i(clk_inv), .rst_ni(rst_n), .chan_en_i(chan_en),
        .vsync_i(vsync), .hsync_i(hsync), .de_i(de), .pix_data_i(pix),
        .win_row_lo_i(rlo), .win_row_hi_i(rhi), .win_col_lo_i(clo), .win_col_hi_i(chi),
        .ref_crc_i(ref_crc), .frame_crc_o(frame_crc), .crc_fail_o(fail)
    );

    int total = 0;
    int bad   = 0;

    typedef struct {
        logic [31:0] crc;
        logic        flag;
        string       tag;
    } exp_t;
    exp_t sb[$];

    logic [31:0] m_crc  = 32'hFFFFFFFF;
    logic [31:0] m_hold = '0;
    bit          m_armed = 0;

    function automatic logic [31:0] ref_step(logic [31:0] c, logic [23:0] d);
        logic [31:0] r = c;
        for (int i = 23; i >= 0; i--) begin
            logic fb = r[31] ^ d[i];
            r = r << 1;
            if (fb) r = r ^ 32'h04C11DB7;
        end
        return r;
    endfunction

    function automatic logic [23:0] px_val(int seed, int r, int c);
        return {8'(r * 37 + seed), 8'(c * 11 + seed * 3), 8'(r ^ c ^ seed ^ 8'h5A)};
    endfunction

    function automatic bit in_win(int r, int c);
        return r >= int'(rlo) && r <= int'(rhi) && c >= int'(clo) && c <= int'(chi);
    endfunction

    function automatic logic [31:0] exp_frame(int rows, int cols, int seed);
        logic [31:0] c = 32'hFFFFFFFF;
        for (int r = 0; r < rows; r++)
            for (int k = 0; k < cols; k++)
                if (in_win(r, k)) c = ref_step(c, px_val(seed, r, k));
        return c;
    endfunction

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s act=%h exp=%h", req, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge pclk);
        #5;
    endtask

    // driver: the frame edge seals the model's running value
    task automatic vs_pulse(string tag);
        exp_t e;
        if (chan_en && m_armed) begin
            m_hold = m_crc;
            e.flag = (m_crc != ref_crc);
        end else begin
            e.flag = 1'b0;
        end
        e.crc = m_hold;
        e.tag = tag;
        sb.push_back(e);
        m_armed = chan_en;
        m_crc   = 32'hFFFFFFFF;
        vsync = 1'b1; tick(); tick();
        vsync = 1'b0; tick(); tick();
    endtask

    task automatic send_lines(int r0, int r1, int cols, int seed);
        for (int r = r0; r < r1; r++) begin
            hsync = 1'b1; tick();
            hsync = 1'b0; tick();
            for (int c = 0; c < cols; c++) begin
                de  = 1'b1;
                pix = px_val(seed, r, c);
                if (chan_en && in_win(r, c)) m_crc = ref_step(m_crc, pix);
                tick();
            end
            de = 1'b0; tick(); tick();
        end
    endtask

    task automatic do_reset(bit inv);
        rst_n = 1'b0; clk_inv = inv; vsync = 1'b0; hsync = 1'b0; de = 1'b0; chan_en = 1'b0;
        repeat (3) tick();
        check("R1 reset crc", frame_crc, 32'h0);
        check("R1 reset fail", {31'b0, fail}, 32'h0);
        sb.delete();
        m_armed = 0; m_hold = '0; m_crc = 32'hFFFFFFFF;
        rst_n = 1'b1; tick();
    endtask

    task automatic compare();
        exp_t e;
        if (sb.size() == 0) begin
            total++; bad++;
            $display("FAIL R4 unexpected frame edge act=result exp=none");
        end else begin
            e = sb.pop_front();
            check(e.tag, frame_crc, e.crc);
            check({e.tag, " flag"}, {31'b0, fail}, {31'b0, e.flag});
        end
    endtask

    // monitor
    initial begin
        bit vs_prev;
        bit pend;
        bit after;
        vs_prev = 0; pend = 0; after = 0;
        forever begin
            @(posedge pclk);
            #15;
            if (!rst_n) begin
                vs_prev = 0; pend = 0; after = 0;
            end else begin
                if (after) begin
                    check("R5 pulse width", {31'b0, fail}, 32'h0);
                    after = 0;
                end
                if (pend) begin
                    compare(); after = 1; pend = 0;
                end
                if (vsync && !vs_prev) begin
                    if (clk_inv) begin compare(); after = 1; end
                    else pend = 1;
                end
                vs_prev = vsync;
            end
        end
    end

    initial begin
        #(200000 * 20);
        total++; bad++;
        $display("FAIL watchdog act=timeout exp=finished");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        do_reset(1'b0);
        chan_en = 1'b1;
        rlo = 12'd1; rhi = 12'd3; clo = 13'd2; chi = 13'd5;
        vs_pulse("R8 first edge seals nothing");
        ref_crc = 32'h0;
        send_lines(0, 5, 8, 1);
        vs_pulse("R2 R5 mismatch frame");
        ref_crc = exp_frame(5, 8, 2);
        send_lines(0, 5, 8, 2);
        vs_pulse("R2 R6 matching frame");
        rlo = 12'd0; rhi = 12'd4; clo = 13'd0; chi = 13'd7;
        ref_crc = exp_frame(5, 8, 3);
        send_lines(0, 5, 8, 3);
        vs_pulse("R3 full inclusive window");
        rlo = 12'd4; rhi = 12'd4; clo = 13'd7; chi = 13'd7;
        ref_crc = 32'h0;
        send_lines(0, 5, 8, 4);
        vs_pulse("R3 single corner pixel");
        rlo = 12'd0; rhi = 12'd4; clo = 13'd5; chi = 13'd2;
        ref_crc = 32'hFFFFFFFF;
        send_lines(0, 5, 8, 5);
        vs_pulse("R7 empty column range");
        rlo = 12'd3; rhi = 12'd1; clo = 13'd0; chi = 13'd7;
        ref_crc = 32'h0;
        send_lines(0, 5, 8, 6);
        vs_pulse("R7 empty row range");
        rlo = 12'd1; rhi = 12'd3; clo = 13'd2; chi = 13'd5;
        chan_en = 1'b0;
        send_lines(0, 5, 8, 7);
        vs_pulse("R8 disabled holds");
        send_lines(0, 2, 8, 8);
        chan_en = 1'b1;
        send_lines(2, 5, 8, 8);
        vs_pulse("R8 partial frame unchecked");
        send_lines(0, 5, 8, 9);
        vs_pulse("R8 first full frame checked");

        do_reset(1'b1);
        chan_en = 1'b1;
        vs_pulse("R9 arm on falling edge");
        ref_crc = exp_frame(5, 8, 10);
        send_lines(0, 5, 8, 10);
        vs_pulse("R9 inverted clock match");
        ref_crc = 32'h12345678;
        send_lines(0, 5, 8, 11);
        vs_pulse("R9 inverted clock mismatch");
        repeat (4) tick();
        check("R4 every edge produced a result", sb.size(), 32'h0);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule